// File: doc/BRIEF.md
# External Interrupt Request Controller

This block keeps one processor's record of pending external interrupts and the mask that selects which of them may interrupt it. Any agent on the system bus, such as a device controller, a timer or another processor, raises an interrupt by writing its interrupt number to a single bus-mapped word. The block turns that number into one pending bit, counted from the most significant end. A timer alarm input raises interrupt 0 through the same path.

Local software, running on the owning processor, clears pending bits by writing ones to their positions. It sets the enable mask by writing a whole new mask. The block drives a level request while any pending bit is also enabled. When the processor's global interrupt enable is set, the block also drives a take strobe and the external-interrupt trap number.

The pending and mask registers are brought out as local read ports. Only full 32-bit bus accesses are honoured. A narrower access changes nothing, reads as zero and pulses an error strobe.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending register, the mask, `bus_rdata`, `bus_err`, `irq_level`, `irq_take` and `trap_code` are all zero.
- R2: A full bus write (`bus_wr_en` with `bus_be` = 4'b1111) of value n sets pending bit (W-1) - (n mod W), visible on `pend_out` the next cycle. W must be a power of two, so with W = 32 interrupt 0 is bit 31 and values 5 and 37 both set bit 26.
- R3: A bus write or timer alarm only sets a bit and never clears any pending bit.
- R4: A bus write with any `bus_be` other than 4'b1111 leaves the pending register unchanged.
- R5: A bus read or write with `bus_be` other than 4'b1111 raises `bus_err` for one cycle, starting the next cycle. A narrow read returns zero on `bus_rdata`. In cycles after no narrow access, `bus_err` is low.
- R6: A full bus read returns, in the next cycle, the pending register as it stood in the read cycle. `bus_rdata` is zero in a cycle that follows no full read.
- R7: A local clear (`clr_en`) clears every pending bit whose position is 1 in `clr_data`, starting the next cycle.
- R8: A local mask write (`mask_wr_en`) replaces the whole mask with `mask_data` from the next cycle.
- R9: `irq_level` is high exactly when the pending register AND the mask is nonzero. It follows each update with no further delay.
- R10: `irq_take` is high exactly when `irq_level` and `psw_ie` are both high. While it is high, `trap_code` carries EXT_TRAP (default 4); otherwise `trap_code` is zero.
- R11: `timer_alarm` sets pending bit W-1 (interrupt 0) the next cycle. It combines with a bus write in the same cycle, so both bits are set.
- R12: When a set and a local clear of the same bit fall in the same cycle, the bit ends up set. Other bits named in the clear are still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write to the interrupt word |
| bus_rd_en | input | 1 | Bus read of the interrupt word |
| bus_be | input | 4 | Bus byte enables; only 4'b1111 is a legal access |
| bus_wdata | input | 32 | Bus write data: the interrupt number |
| bus_rdata | output | W | Bus read data, one cycle after the read |
| bus_err | output | 1 | One-cycle strobe after a narrow bus access |
| timer_alarm | input | 1 | Raises interrupt 0 |
| clr_en | input | 1 | Local clear strobe |
| clr_data | input | W | Ones mark the pending bits to clear |
| mask_wr_en | input | 1 | Local mask write strobe |
| mask_data | input | W | New mask value |
| psw_ie | input | 1 | Processor global interrupt enable |
| pend_out | output | W | Pending register |
| mask_out | output | W | Mask register |
| irq_level | output | 1 | Level request: some enabled bit is pending |
| irq_take | output | 1 | Request taken under the global enable |
| trap_code | output | TRAP_W | Trap number while taken, else zero |

## Verification
A wrong pending or mask bit shows on `pend_out` or `mask_out` in the cycle after the write that caused it. It shows the same cycle on `irq_level` and `irq_take` whenever that bit is both pending and enabled. A full bus read brings it out on `bus_rdata` one cycle after the read. A wrong bit-number mapping or a lost set under a simultaneous clear stays latched in the pending register. So it stays visible until a clear removes it, and the bench compares every output against its model on every cycle.

// File: rtl/ext_irq_pkg.sv
// Shared constants and types for the external interrupt request controller.
// Assumes a 32-bit bus word with four byte enables.
package ext_irq_pkg;
    localparam int BUS_W = 32;
    localparam int BE_W  = BUS_W / 8;
    localparam logic [BE_W-1:0] BE_FULL = '1;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_WRITE   = 2'd1,
        ACC_READ    = 2'd2,
        ACC_PARTIAL = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/eirq_bus_port.sv
// Bus side of the controller: classifies each access, decodes the interrupt
// number into a one-hot set vector counted from the MSB, merges the timer
// alarm as interrupt 0, and registers read data and the error strobe.
// Assumes W is a power of two no larger than 2**32.
module eirq_bus_port
    import ext_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [BE_W-1:0]        be,
    input  logic [BUS_W-1:0]       wdata,
    input  logic                   timer_alarm,
    input  logic [W-1:0]           pend_q,
    output logic [W-1:0]           set_vec,
    output logic [W-1:0]           rdata,
    output logic                   err
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

    acc_kind_t       kind;
    logic            full_wr;
    logic            full_rd;
    logic [W-1:0]    num_hit;
    logic [W-1:0]    timer_vec;

    // Classify the current access; a narrow access overrides read and write.
    always_comb begin
        kind = ACC_IDLE;
        if ((wr_en || rd_en) && (be != BE_FULL)) begin
            kind = ACC_PARTIAL;
        end else if (wr_en) begin
            kind = ACC_WRITE;
        end else if (rd_en) begin
            kind = ACC_READ;
        end
    end

    assign full_wr = (kind == ACC_WRITE);
    assign full_rd = (kind == ACC_READ) || (wr_en && rd_en && be == BE_FULL);

    // One comparator per pending bit: bit i answers to number W-1-i (mod W).
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign num_hit[i] = full_wr && (wdata[IDX_W-1:0] == IDX_W'(W - 1 - i));
    end

    // Timer alarm behaves as a write of interrupt number 0.
    assign timer_vec = {timer_alarm, {(W-1){1'b0}}};
    assign set_vec   = num_hit | timer_vec;

    // Register read data (zero unless a full read) and the narrow-access error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= full_rd ? pend_q : '0;
            err   <= (kind == ACC_PARTIAL);
        end
    end
endmodule

// File: rtl/eirq_pending_reg.sv
// Pending interrupt register. Sets come from the bus port, clears from local
// software; a set wins over a clear of the same bit so no event is lost.
module eirq_pending_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] clr_vec;

    assign clr_vec = clr_en ? clr_data : '0;

    // Apply the clear first, then OR in the sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/eirq_mask_reg.sv
// Interrupt enable mask, replaced whole by each local write.
module eirq_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask_q
);
    // Load the full mask on a write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end
endmodule

// File: rtl/eirq_req_gate.sv
// Request logic: level request from pending AND mask, gated by the global
// interrupt enable into a take strobe carrying the external trap number.
// Purely combinational; assumes EXT_TRAP fits in TRAP_W bits.
module eirq_req_gate #(
    parameter int W        = 32,
    parameter int TRAP_W   = 5,
    parameter int EXT_TRAP = 4
) (
    input  logic [W-1:0]      pend_q,
    input  logic [W-1:0]      mask_q,
    input  logic              psw_ie,
    output logic              irq_level,
    output logic              irq_take,
    output logic [TRAP_W-1:0] trap_code
);
    localparam logic [TRAP_W-1:0] TRAP_VAL = TRAP_W'(EXT_TRAP);

    // Reduce the enabled pending set and gate it.
    always_comb begin
        irq_level = |(pend_q & mask_q);
        irq_take  = irq_level && psw_ie;
        trap_code = irq_take ? TRAP_VAL : '0;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Top of the external interrupt request controller: one bus-mapped word that
// raises interrupts by number, local clear and mask writes, and the request
// to the core. Assumes W is a power of two.
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int W        = 32,
    parameter int TRAP_W   = 5,
    parameter int EXT_TRAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              bus_err,
    input  logic              timer_alarm,
    input  logic              clr_en,
    input  logic [W-1:0]      clr_data,
    input  logic              mask_wr_en,
    input  logic [W-1:0]      mask_data,
    input  logic              psw_ie,
    output logic [W-1:0]      pend_out,
    output logic [W-1:0]      mask_out,
    output logic              irq_level,
    output logic              irq_take,
    output logic [TRAP_W-1:0] trap_code
);
    logic [W-1:0] set_vec;
    logic [W-1:0] pend_q;
    logic [W-1:0] mask_q;

    eirq_bus_port #(.W(W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr_en), .rd_en(bus_rd_en), .be(bus_be), .wdata(bus_wdata),
        .timer_alarm(timer_alarm), .pend_q(pend_q),
        .set_vec(set_vec), .rdata(bus_rdata), .err(bus_err)
    );

    eirq_pending_reg #(.W(W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_en(clr_en), .clr_data(clr_data), .pend_q(pend_q)
    );

    eirq_mask_reg #(.W(W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en),
        .wr_data(mask_data), .mask_q(mask_q)
    );

    eirq_req_gate #(.W(W), .TRAP_W(TRAP_W), .EXT_TRAP(EXT_TRAP)) u_gate (
        .pend_q(pend_q), .mask_q(mask_q), .psw_ie(psw_ie),
        .irq_level(irq_level), .irq_take(irq_take), .trap_code(trap_code)
    );

    assign pend_out = pend_q;
    assign mask_out = mask_q;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
// Checker for ext_irq_ctrl, bound to every instance. Relates port activity
// in one cycle to register contents in the next.
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr_en,
    input logic            bus_rd_en,
    input logic [BE_W-1:0] bus_be,
    input logic            timer_alarm,
    input logic            clr_en,
    input logic [W-1:0]    clr_data,
    input logic            mask_wr_en,
    input logic [W-1:0]    mask_data,
    input logic            psw_ie,
    input logic [W-1:0]    pend_out,
    input logic [W-1:0]    mask_out,
    input logic            bus_err,
    input logic            irq_level,
    input logic            irq_take
);
    logic narrow;
    assign narrow = (bus_wr_en || bus_rd_en) && (bus_be != BE_FULL);

    assert_or_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((pend_out & $past(pend_out)) == $past(pend_out)));

    assert_narrow_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_be != BE_FULL && !timer_alarm && !clr_en)
        |=> (pend_out == $past(pend_out)));

    assert_err_on_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |=> bus_err);

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !narrow |=> !bus_err);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !bus_wr_en && !timer_alarm)
        |=> ((pend_out & $past(clr_data)) == '0));

    assert_mask_replace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (mask_out == $past(mask_data)));

    assert_take_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_level && psw_ie));

    assert_timer_sets_msb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timer_alarm |=> pend_out[W-1]);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_be(bus_be), .timer_alarm(timer_alarm), .clr_en(clr_en),
    .clr_data(clr_data), .mask_wr_en(mask_wr_en), .mask_data(mask_data),
    .psw_ie(psw_ie), .pend_out(pend_out), .mask_out(mask_out),
    .bus_err(bus_err), .irq_level(irq_level), .irq_take(irq_take)
);

// File: tb/tb_ext_irq_ctrl.sv
// Bench for ext_irq_ctrl: behavioural reference model updated on each rising
// edge, all outputs compared on each falling edge, plus directed checks.
module tb_ext_irq_ctrl;
    localparam int W = 32;
    localparam int TW = 5;
    localparam logic [TW-1:0] TRAP = 5'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 0, bus_rd_en = 0, timer_alarm = 0;
    logic clr_en = 0, mask_wr_en = 0, psw_ie = 0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [W-1:0] clr_data = '0, mask_data = '0;
    logic [W-1:0] bus_rdata, pend_out, mask_out;
    logic bus_err, irq_level, irq_take;
    logic [TW-1:0] trap_code;

    int n_chk = 0;
    int n_fail = 0;
    bit comparing = 0;
    bit finished = 0;

    // reference state
    logic [W-1:0] m_pend = '0, m_mask = '0, m_rdata = '0;
    logic m_err = 0;

    always #10 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .timer_alarm(timer_alarm), .clr_en(clr_en),
        .clr_data(clr_data), .mask_wr_en(mask_wr_en), .mask_data(mask_data),
        .psw_ie(psw_ie), .pend_out(pend_out), .mask_out(mask_out),
        .irq_level(irq_level), .irq_take(irq_take), .trap_code(trap_code)
    );

    // Reference model: one update per rising edge from the requirements.
    always @(posedge clk) begin
        logic [W-1:0] nxt;
        bit narrow;
        bit full_wr;
        bit full_rd;
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_rdata = '0; m_err = 0;
        end else begin
            narrow  = (bus_wr_en || bus_rd_en) && bus_be != 4'hF;
            full_wr = bus_wr_en && !narrow;
            full_rd = bus_rd_en && !narrow;
            m_rdata = full_rd ? m_pend : '0;
            m_err   = narrow;
            nxt = m_pend;
            if (clr_en) nxt = nxt & ~clr_data;
            if (full_wr) nxt[(W-1) - (bus_wdata % W)] = 1'b1;
            if (timer_alarm) nxt[W-1] = 1'b1;
            m_pend = nxt;
            if (mask_wr_en) m_mask = mask_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the model.
    always @(negedge clk) begin
        bit lvl;
        if (comparing) begin
            lvl = |(m_pend & m_mask);
            chk("R3 pend", pend_out, m_pend);
            chk("R8 mask", mask_out, m_mask);
            chk("R9 irq_level", 32'(irq_level), 32'(lvl));
            chk("R10 irq_take", 32'(irq_take), 32'(lvl && psw_ie));
            chk("R10 trap_code", 32'(trap_code), (lvl && psw_ie) ? 32'(TRAP) : 32'd0);
            chk("R6 rdata", bus_rdata, m_rdata);
            chk("R5 err", 32'(bus_err), 32'(m_err));
        end
    end

    task automatic idle();
        bus_wr_en = 0; bus_rd_en = 0; bus_be = 4'hF; timer_alarm = 0;
        clr_en = 0; mask_wr_en = 0;
    endtask

    // Apply one cycle of stimulus, then wait until outputs reflect it.
    task automatic step();
        @(negedge clk);
        #1;
        idle();
    endtask

    task automatic bwr(input logic [31:0] n, input logic [3:0] be);
        bus_wr_en = 1; bus_wdata = n; bus_be = be;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 pend", pend_out, 0); chk("R1 mask", mask_out, 0);
        chk("R1 rdata", bus_rdata, 0); chk("R1 err", 32'(bus_err), 0);
        chk("R1 irq", 32'(irq_level), 0); chk("R1 take", 32'(irq_take), 0);
        chk("R1 trap", 32'(trap_code), 0);
        comparing = 1;

        bwr(0, 4'hF); step();
        chk("R2 int0 is MSB", pend_out, 32'h8000_0000);
        bwr(5, 4'hF); step();
        bwr(37, 4'hF); step();
        chk("R3 R2 or-in and mod", pend_out, 32'h8400_0000);
        bwr(3, 4'h3); step();
        chk("R4 narrow write ignored", pend_out, 32'h8400_0000);
        chk("R5 err raised", 32'(bus_err), 1);
        step();
        chk("R5 err one cycle", 32'(bus_err), 0);
        bus_rd_en = 1; step();
        chk("R6 read", bus_rdata, 32'h8400_0000);
        step();
        chk("R6 rdata zero after", bus_rdata, 0);
        bus_rd_en = 1; bus_be = 4'h1; step();
        chk("R5 narrow read zero", bus_rdata, 0);
        chk("R5 narrow read err", 32'(bus_err), 1);
        clr_en = 1; clr_data = 32'h8000_0000; step();
        chk("R7 clear", pend_out, 32'h0400_0000);
        chk("R9 masked off", 32'(irq_level), 0);
        mask_wr_en = 1; mask_data = 32'h0400_0000; step();
        chk("R8 mask", mask_out, 32'h0400_0000);
        chk("R9 level", 32'(irq_level), 1);
        chk("R10 no take without ie", 32'(irq_take), 0);
        psw_ie = 1; #1;
        chk("R10 take", 32'(irq_take), 1);
        chk("R10 trap", 32'(trap_code), 32'(TRAP));
        timer_alarm = 1; bwr(2, 4'hF); step();
        chk("R11 timer plus bus", pend_out, 32'hA400_0000);
        bwr(1, 4'hF); clr_en = 1; clr_data = 32'h4400_0000; step();
        chk("R12 set wins", pend_out, 32'hE000_0000);
        chk("R9 drop after clear", 32'(irq_level), 0);

        // random traffic under model comparison
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            idle();
            bus_wr_en   = ($urandom_range(0, 3) == 0);
            bus_rd_en   = ($urandom_range(0, 3) == 0);
            bus_be      = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF;
            bus_wdata   = $urandom;
            timer_alarm = ($urandom_range(0, 15) == 0);
            clr_en      = ($urandom_range(0, 3) == 0);
            clr_data    = $urandom & $urandom;
            mask_wr_en  = ($urandom_range(0, 15) == 0);
            mask_data   = $urandom;
            psw_ie      = 1'($urandom);
        end
        @(negedge clk); #1 idle();
        repeat (2) @(negedge clk);
        comparing = 0;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule